// File: doc/BRIEF.md
# CPU Reset and Halt Supervisor

This block generates reset for a processor whose active-low RESET and HALT lines are shared, bidirectional wires. The supervisor never drives either wire high. It owns one open-drain pull-down per wire, modelled here as an enable: 1 pulls the wire low, and 0 leaves the output at high impedance so that an external pull-up returns the wire high. After power-up, or after an accepted press of the pushbutton, it pulls both wires low together for a fixed window. Asserting HALT together with RESET makes sure the processor is really reset, even while it is executing its own peripheral-reset instruction, which pulls RESET low.

The two enables are separate, so a HALT pulled low by the processor, for instance after a double bus fault, never turns into a reset. The block reads both wire levels through a two-stage synchronizer. It drives a status LED from the sensed HALT level. It raises a sticky fault flag when HALT goes low and the supervisor is not the one pulling it. The flag is armed only after both wires have been seen high again following the block's own release. The pulse length and the debounce length are parameters counted in clock cycles. The defaults give 100 ms and 10 ms at 200 MHz.

Top module: `cpu_reset_supervisor`

## Requirements
- R1: While rst_n is low, and for exactly PULSE_CYC clock cycles after it goes high, both pull enables are 1 (1 = pull the wire low, 0 = high impedance). After that window both enables are 0.
- R2: The two pull enables are always equal. Both wires are asserted from one source, each through its own output.
- R3: The raw button (1 = pressed) passes a two-stage synchronizer. A level change is accepted only after the synchronized level has differed from the accepted level for DEB_CYC consecutive cycles. A press shorter than DEB_CYC cycles has no effect on the enables.
- R4: An accepted press sets both enables to 1 starting DEB_CYC+3 clock cycles after the first edge that samples the press. The enables stay at 1 for PULSE_CYC cycles. Releasing the button starts nothing.
- R5: An accepted press while a pulse is running restarts the full PULSE_CYC window from the cycle the press is accepted.
- R6: HALT pulled low by the processor never sets either enable.
- R7: RESET pulled low by the processor alone sets no enable and raises no fault.
- R8: halt_fault_o rises on the third clock edge after the HALT wire falls, provided the block is not pulling and both wires have read high since its last release. The flag then stays 1 after HALT returns high.
- R9: halt_fault_o clears on the edge where an accepted press starts a new pulse, and on reset.
- R10: halt_led_o equals the inverse of the HALT wire level two clock edges earlier (1 = HALT low).
- R11: The block's own pull, and the settling cycles after its release, never raise halt_fault_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| btn_raw | input | 1 | Unsynchronized pushbutton level, 1 = pressed |
| rst_line_i | input | 1 | Sensed level of the shared RESET wire |
| hlt_line_i | input | 1 | Sensed level of the shared HALT wire |
| rst_pull_o | output | 1 | Open-drain enable for RESET, 1 = pull low |
| hlt_pull_o | output | 1 | Open-drain enable for HALT, 1 = pull low |
| halt_led_o | output | 1 | LED drive, 1 while HALT is sensed low |
| halt_fault_o | output | 1 | Sticky flag: HALT went low without this block pulling it |

## Verification
The bench drives press lengths at the debounce limit and one cycle under it. An off-by-one debounce counter would either accept the short glitch or reject the exact-length press. It presses a second time in the middle of a pulse and measures the total assertion time; a timer that ignores restarts ends the pulse early. It also models the pull-ups, so the wire follows the block's own release. A detector that is not blanked until both wires read high again would flag the block's own reset as a fault. Finally, a processor-held HALT and a processor-held RESET are each applied alone: any feedback into the enables, a missing sticky behaviour, or a flag not cleared by the next press shows up at the ports.

// File: rtl/rsv_pkg.sv
// Shared types for the reset supervisor.
// Assumes: both wires are active low and read back through the same synchronizer.
package rsv_pkg;

    // Synchronized levels of the two shared wires (1 = wire high)
    typedef struct packed {
        logic rst;
        logic hlt;
    } line_pair_t;

endpackage

// File: rtl/rsv_sync.sv
// Multi-stage synchronizer for a W-bit group of asynchronous inputs.
// Assumes: each bit is independent; bits may settle on different cycles.
module rsv_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage captures the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= d;
                end
            end else begin : g_next
                // Later stages give a metastable value time to resolve
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/rsv_debounce.sv
// Pushbutton debouncer. A level change is accepted once the synchronized
// level has differed from the accepted level for DEB_CYC consecutive cycles.
// Emits a one-cycle pulse when a press (0 -> 1) is accepted.
// Assumes: DEB_CYC >= 1; the button is 1 while pressed.
module rsv_debounce #(
    parameter int DEB_CYC = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic press_o
);

    localparam int DW = $clog2(DEB_CYC + 1);

    logic          synced;
    logic          stable;
    logic [DW-1:0] dcnt;

    rsv_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw),
        .q    (synced)
    );

    // Count cycles of disagreement and accept the new level when the count runs out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable  <= 1'b0;
            dcnt    <= '0;
            press_o <= 1'b0;
        end else begin
            press_o <= 1'b0;
            if (synced == stable) begin
                dcnt <= '0;
            end else if (dcnt == DW'(DEB_CYC - 1)) begin
                stable  <= synced;
                dcnt    <= '0;
                press_o <= synced;
            end else begin
                dcnt <= dcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rsv_pulse_timer.sv
// Reset window timer. Loaded on reset and on every start request; the pull
// request is active while the count is non-zero.
// Assumes: PULSE_CYC >= 1.
module rsv_pulse_timer #(
    parameter int PULSE_CYC = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic pull_o
);

    localparam int CW = $clog2(PULSE_CYC + 1);

    logic [CW-1:0] cnt;

    // Reload on reset or start request, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= CW'(PULSE_CYC);
        else if (start_i)    cnt <= CW'(PULSE_CYC);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign pull_o = (cnt != '0);

endmodule

// File: rtl/rsv_fault_mon.sv
// Halt-fault monitor. Arms once both wires read high with no pull active,
// then flags HALT low as a processor-caused halt. The flag is sticky until
// the supervisor starts a new reset.
// Assumes: sensed levels are already synchronized.
module rsv_fault_mon
    import rsv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pull_i,
    input  logic       start_i,
    input  line_pair_t sensed_i,
    output logic       fault_o
);

    logic armed;

    // Disarm while pulling; rearm when both wires have returned high
    always_ff @(posedge clk) begin
        if (!rst_n)                             armed <= 1'b0;
        else if (pull_i)                        armed <= 1'b0;
        else if (sensed_i.rst && sensed_i.hlt)  armed <= 1'b1;
    end

    // Latch a foreign halt; a new reset from this block clears it
    always_ff @(posedge clk) begin
        if (!rst_n)                                 fault_o <= 1'b0;
        else if (start_i)                           fault_o <= 1'b0;
        else if (armed && !pull_i && !sensed_i.hlt) fault_o <= 1'b1;
    end

endmodule

// File: rtl/cpu_reset_supervisor.sv
// Reset and halt supervisor for a processor with shared open-drain RESET and
// HALT wires. Generates a power-up pulse, restarts it on a debounced press,
// drives both wires through separate pull-down enables, and flags halts that
// the processor causes.
// Assumes: external pull-ups on both wires; enables map to open-drain pads.
module cpu_reset_supervisor
    import rsv_pkg::*;
#(
    parameter int PULSE_CYC = 20_000_000,
    parameter int DEB_CYC   = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    input  logic rst_line_i,
    input  logic hlt_line_i,
    output logic rst_pull_o,
    output logic hlt_pull_o,
    output logic halt_led_o,
    output logic halt_fault_o
);

    logic       press;
    logic       pull;
    logic [1:0] line_q;
    line_pair_t sensed;

    rsv_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (btn_raw),
        .press_o(press)
    );

    rsv_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(press),
        .pull_o (pull)
    );

    rsv_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_line_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({rst_line_i, hlt_line_i}),
        .q    (line_q)
    );

    assign sensed = '{rst: line_q[1], hlt: line_q[0]};

    rsv_fault_mon u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .pull_i  (pull),
        .start_i (press),
        .sensed_i(sensed),
        .fault_o (halt_fault_o)
    );

    // One request drives both pads; each pad stays its own open-drain output
    assign rst_pull_o = pull;
    assign hlt_pull_o = pull;
    assign halt_led_o = ~sensed.hlt;

endmodule

// File: rtl/rsv_checker.sv
// Property checker for cpu_reset_supervisor, attached through bind.
module rsv_checker (
    input logic clk,
    input logic rst_n,
    input logic hlt_line_i,
    input logic rst_pull_o,
    input logic hlt_pull_o,
    input logic halt_led_o,
    input logic halt_fault_o
);

    // R2: both pads carry the same request
    p_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pull_o == hlt_pull_o);

    // R8: a new fault needs HALT low at the synchronizer input two edges back
    p_fault_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_fault_o) |-> !$past(hlt_line_i, 2));

    // R11: no fault rises while the block itself is pulling
    p_no_self_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_fault_o) |-> !$past(hlt_pull_o));

    // R9: a pulse started by the block begins with the flag cleared
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlt_pull_o) |-> !halt_fault_o);

    // R10: LED mirrors the HALT wire two edges late
    p_led_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (halt_led_o == !$past(hlt_line_i, 2)));

endmodule

bind cpu_reset_supervisor rsv_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hlt_line_i  (hlt_line_i),
    .rst_pull_o  (rst_pull_o),
    .hlt_pull_o  (hlt_pull_o),
    .halt_led_o  (halt_led_o),
    .halt_fault_o(halt_fault_o)
);

// File: tb/cpu_reset_supervisor_test.sv
`timescale 1ns/1ps
module cpu_reset_supervisor_test;

    localparam int P = 40;
    localparam int D = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic btn_raw = 1'b0;
    logic cpu_rst_drv = 1'b0;
    logic cpu_hlt_drv = 1'b0;
    logic rst_pull_o, hlt_pull_o, halt_led_o, halt_fault_o;
    logic rst_line, hlt_line;

    // Wires with pull-ups: low if either side pulls
    assign rst_line = !(rst_pull_o || cpu_rst_drv);
    assign hlt_line = !(hlt_pull_o || cpu_hlt_drv);

    cpu_reset_supervisor #(.PULSE_CYC(P), .DEB_CYC(D)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .btn_raw     (btn_raw),
        .rst_line_i  (rst_line),
        .hlt_line_i  (hlt_line),
        .rst_pull_o  (rst_pull_o),
        .hlt_pull_o  (hlt_pull_o),
        .halt_led_o  (halt_led_o),
        .halt_fault_o(halt_fault_o)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected first asserted sample index (-1 = none)
    function automatic int exp_first(input int l1);
        return (l1 >= D) ? D + 3 : -1;
    endfunction

    // Expected count of asserted samples for one or two presses
    function automatic int exp_count(input int l1, input int t2, input int l2);
        if (l1 < D) return 0;
        if (t2 > 0 && l2 >= D) return t2 + P;
        return P;
    endfunction

    // Run a press schedule; sample n is taken after edge n
    task automatic run_sched(input int l1, input int t2, input int l2,
                             output int first, output int cnt, output int flt_first);
        int len;
        len = t2 + l2 + 3 * D + P + 20;
        first = -1; cnt = 0; flt_first = 0;
        btn_raw = (l1 > 0);
        for (int n = 1; n <= len; n++) begin
            @(negedge clk);
            chk(rst_pull_o == hlt_pull_o, "R2", rst_pull_o, hlt_pull_o);
            if (hlt_pull_o) begin
                if (first < 0) begin
                    first = n;
                    flt_first = halt_fault_o;
                end
                cnt++;
            end
            btn_raw = (n < l1) || (t2 > 0 && n >= t2 && n < t2 + l2);
        end
        btn_raw = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int first, cnt, ff, n, l;
        void'($urandom(32'd4711));

        // R1: enables held during reset and for P cycles after release
        repeat (4) @(negedge clk);
        chk(rst_pull_o && hlt_pull_o, "R1 during reset", rst_pull_o, 1);
        rst_n = 1'b1;
        n = 0;
        while (hlt_pull_o && n < 10 * P) begin
            n++;
            @(negedge clk);
        end
        chk(n == P, "R1 power-on length", n, P);
        repeat (10) @(negedge clk);
        chk(!rst_pull_o && !hlt_pull_o, "R1 released", rst_pull_o, 0);
        // R11: own release leaves no fault; R10 LED dark with HALT high
        chk(!halt_fault_o, "R11 after power-on", halt_fault_o, 0);
        chk(!halt_led_o, "R10 led idle", halt_led_o, 0);

        // R3/R4: press of exactly D cycles is accepted
        run_sched(D, 0, 0, first, cnt, ff);
        chk(first == exp_first(D), "R4 latency", first, exp_first(D));
        chk(cnt == exp_count(D, 0, 0), "R4 length", cnt, exp_count(D, 0, 0));

        // R3: glitch of D-1 cycles is ignored
        run_sched(D - 1, 0, 0, first, cnt, ff);
        chk(cnt == 0, "R3 short glitch", cnt, 0);

        // R5: second press inside the pulse restarts the window
        run_sched(D + 2, 26, D + 2, first, cnt, ff);
        chk(first == exp_first(D + 2), "R5 first", first, exp_first(D + 2));
        chk(cnt == exp_count(D + 2, 26, D + 2), "R5 restart length", cnt,
            exp_count(D + 2, 26, D + 2));

        // R3/R4: random press lengths around the limit
        for (int k = 0; k < 8; k++) begin
            l = 1 + int'($urandom % (2 * D));
            run_sched(l, 0, 0, first, cnt, ff);
            chk(first == exp_first(l), "R3 random latency", first, exp_first(l));
            chk(cnt == exp_count(l, 0, 0), "R4 random length", cnt, exp_count(l, 0, 0));
        end

        // R7: processor pulls RESET alone
        @(negedge clk);
        cpu_rst_drv = 1'b1;
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (hlt_pull_o || rst_pull_o || halt_fault_o) n++;
        end
        cpu_rst_drv = 1'b0;
        chk(n == 0, "R7 cpu reset ignored", n, 0);
        repeat (5) @(negedge clk);

        // R8/R10/R6: processor pulls HALT
        cpu_hlt_drv = 1'b1;
        @(negedge clk);
        chk(!halt_led_o, "R10 led one edge", halt_led_o, 0);
        @(negedge clk);
        chk(halt_led_o, "R10 led two edges", halt_led_o, 1);
        chk(!halt_fault_o, "R8 fault not yet", halt_fault_o, 0);
        @(negedge clk);
        chk(halt_fault_o, "R8 fault third edge", halt_fault_o, 1);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (hlt_pull_o || rst_pull_o) n++;
        end
        chk(n == 0, "R6 no feedback", n, 0);
        cpu_hlt_drv = 1'b0;
        repeat (5) @(negedge clk);
        chk(halt_fault_o, "R8 sticky", halt_fault_o, 1);
        chk(!halt_led_o, "R10 led off", halt_led_o, 0);

        // R9: next press clears the flag; R11: no fault after that release
        run_sched(D + 1, 0, 0, first, cnt, ff);
        chk(first == exp_first(D + 1), "R9 press accepted", first, exp_first(D + 1));
        chk(ff == 0, "R9 cleared at start", ff, 0);
        chk(!halt_fault_o, "R11 after own pulse", halt_fault_o, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule